// File: doc/BRIEF.md
# Inertial Sensor Packet FIFO

This block buffers motion-sensor samples between the sensor data path and a host. The data path offers one complete 12-byte sample packet at a time, and the block stores it in a single cycle. The host drains the buffer one byte per read request and can watch a live byte count. A 2-bit fill policy selects how the buffer behaves. It can ignore all packets (bypass), fill once and then reject new packets (hold), or keep the newest data by discarding the oldest whole packets (ring).

Two flags report the buffer state. One shows that no room is left for another packet. The other shows that the byte count has reached a programmable byte watermark. Each flag has its own enable bit, and the enabled flags are combined onto one active-low interrupt line. All settings are loaded together through a single configuration strobe. Loading a different fill policy empties the buffer.

Top module: `imu_sample_fifo`

## Requirements
- R1: After a synchronous active-low reset, the fill policy is bypass, the byte count is 0, both interrupt enables and the watermark are 0, `int_n` is high and `rd_data` is 0x00.
- R2: Policy codes are 00 bypass, 01 hold, 11 ring and 10 reserved. Under bypass or the reserved code, offered packets are ignored and the byte count stays 0.
- R3: An accepted packet adds 12 to the byte count on the next clock. Byte k of the packet is `pkt_data[8k+7:8k]`. Reads return bytes oldest first, starting with byte 0, and `rd_data` is updated one clock after `rd_req`.
- R4: Capacity is 2048 bytes. In hold mode, a packet is stored only when at least 12 bytes are free, judged on the count before any read in the same cycle. Otherwise the whole packet is discarded and the stored data is left intact.
- R5: In ring mode, a packet arriving with fewer than 12 bytes free first discards the rest of the oldest, possibly part-read, packet. If fewer than 12 bytes are still free, it also discards the next whole packet. The new packet is then stored, so the read position always stays on a packet boundary.
- R6: A read with a count of 0 returns 0x00 and leaves the count unchanged. Otherwise a read removes one byte. A read together with an accepted packet changes the count by +11.
- R7: A configuration write with a policy code different from the current one empties the buffer. A packet or read in that same cycle is ignored, and such a read returns 0x00. A configuration write with the same code keeps the contents.
- R8: `ths_flag` is high while the watermark is non-zero and the byte count is at least the watermark. It drops once reads bring the count below the watermark.
- R9: `full_flag` is high while fewer than 12 bytes are free, that is, while the count is above 2036.
- R10: `int_n` is low exactly when (`full_flag` and the full enable) or (`ths_flag` and the threshold enable) holds. With both enables at 0 it stays high whatever the buffer holds.
- R11: A read in the same cycle as a ring-mode overwrite returns the oldest byte. That byte counts among the discarded bytes, so the count becomes the old count minus the discarded bytes plus 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load all configuration fields this cycle |
| cfg_mode | input | 2 | Fill policy code (00 bypass, 01 hold, 11 ring, 10 reserved) |
| cfg_full_en | input | 1 | Route the full flag to the interrupt |
| cfg_ths_en | input | 1 | Route the threshold flag to the interrupt |
| cfg_wm | input | 12 | Watermark in bytes; 0 disables the threshold flag |
| pkt_valid | input | 1 | A sample packet is offered this cycle |
| pkt_data | input | 96 | Packet bytes, byte 0 in the low bits |
| rd_req | input | 1 | Host read of one byte |
| rd_data | output | 8 | Byte returned by the last read |
| byte_count | output | 12 | Bytes currently held |
| full_flag | output | 1 | Fewer than one packet of free space |
| ths_flag | output | 1 | Count at or above the watermark |
| int_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `rst_n` is low for at least one clock at start-up and that the inputs are settled at every rising edge. They also assume that a read may arrive on an empty buffer, and the design is expected to absorb that without any protection from the host. The bench changes inputs only 1 ns after each edge, and every stimulus it applies is legal. It issues reads on an empty buffer on purpose. It reaches the double discard in ring mode by reading 11 bytes of the oldest packet while the buffer is nearly full, and then offering two more packets.

// File: rtl/imu_fifo_pkg.sv
// Shared types for the sensor packet FIFO.
// Assumes nothing beyond a 2-bit policy code.
package imu_fifo_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'b00,
        MODE_HOLD   = 2'b01,
        MODE_RSVD   = 2'b10,
        MODE_RING   = 2'b11
    } fill_mode_e;

endpackage

// File: rtl/imu_fifo_ctrl.sv
// Pointer, count and policy control for the packet FIFO.
// Decides each cycle whether a packet is stored, whether old packets are
// discarded to make room, and whether a host read consumes a byte.
// Assumes DEPTH is a power of two and PKT is at least 2 and below DEPTH.
module imu_fifo_ctrl
    import imu_fifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int PKT   = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  fill_mode_e                   cfg_mode,
    input  logic                         pkt_valid,
    input  logic                         rd_req,
    output logic                         wr_en,
    output logic [$clog2(DEPTH)-1:0]     wr_ptr,
    output logic                         rd_en,
    output logic                         rd_zero,
    output logic [$clog2(DEPTH)-1:0]     rd_ptr,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int OW = $clog2(PKT);
    localparam logic [CW-1:0] PKT_C   = CW'(PKT);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [OW-1:0] OFS_LAST = OW'(PKT - 1);

    fill_mode_e       mode_q;
    logic [CW-1:0]    count_q;
    logic [PW-1:0]    rptr_q;
    logic [PW-1:0]    wptr_q;
    logic [OW-1:0]    ofs_q;

    logic             flush_w;
    logic             fits_w;
    logic             rd_ok_w;
    logic             acc_hold_w;
    logic             acc_ring_w;
    logic             ovw_w;
    logic             wr_ok_w;
    logic [CW-1:0]    free_w;
    logic [CW-1:0]    take_w;
    logic [CW-1:0]    drop_w;

    // Decode this cycle's accept, read and discard decisions.
    always_comb begin
        free_w     = DEPTH_C - count_q;
        fits_w     = (free_w >= PKT_C);
        flush_w    = cfg_we && (cfg_mode != mode_q);
        rd_ok_w    = rd_req && (count_q != '0) && !flush_w;
        acc_hold_w = pkt_valid && !flush_w && (mode_q == MODE_HOLD) && fits_w;
        acc_ring_w = pkt_valid && !flush_w && (mode_q == MODE_RING);
        ovw_w      = acc_ring_w && !fits_w;
        wr_ok_w    = acc_hold_w || acc_ring_w;
        take_w     = PKT_C - CW'(ofs_q);
        drop_w     = ((free_w + take_w) >= PKT_C) ? take_w : (take_w + PKT_C);
    end

    // Policy register, pointers, count and in-packet read offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_BYPASS;
            count_q <= '0;
            rptr_q  <= '0;
            wptr_q  <= '0;
            ofs_q   <= '0;
        end else if (flush_w) begin
            mode_q  <= cfg_mode;
            count_q <= '0;
            rptr_q  <= '0;
            wptr_q  <= '0;
            ofs_q   <= '0;
        end else begin
            if (ovw_w) begin
                rptr_q  <= rptr_q + PW'(drop_w);
                count_q <= count_q - drop_w + PKT_C;
                ofs_q   <= '0;
            end else begin
                if (rd_ok_w) begin
                    rptr_q <= rptr_q + PW'(1);
                    ofs_q  <= (ofs_q == OFS_LAST) ? '0 : ofs_q + OW'(1);
                end
                count_q <= count_q + (wr_ok_w ? PKT_C : '0) - (rd_ok_w ? CW'(1) : '0);
            end
            if (wr_ok_w) begin
                wptr_q <= wptr_q + PW'(PKT);
            end
        end
    end

    // Drive the storage and outward-facing count.
    always_comb begin
        wr_en   = wr_ok_w;
        wr_ptr  = wptr_q;
        rd_en   = rd_ok_w;
        rd_zero = rd_req && !rd_ok_w;
        rd_ptr  = rptr_q;
        count   = count_q;
    end

    // R2
    // bypass_empty_chk
    bypass_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BYPASS || mode_q == MODE_RSVD) |-> (count_q == '0));

    // R4
    // hold_reject_chk
    hold_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD && pkt_valid && !fits_w && !cfg_we && !rd_req)
        |=> $stable(count_q));

    // R4
    // no_overflow_chk
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= DEPTH_C);

    // R5
    // ring_store_chk
    ring_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RING && pkt_valid && !cfg_we) |=> (count_q >= PKT_C));

    // R7
    // flush_empty_chk
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_mode != mode_q) |=> (count_q == '0));

endmodule

// File: rtl/imu_fifo_store.sv
// Byte storage for the packet FIFO: a whole packet is written in one cycle
// at consecutive byte addresses, wrapping at the end; one byte is read per cycle.
// Assumes the controller never writes bytes that still hold unread data.
module imu_fifo_store #(
    parameter int DEPTH = 2048,
    parameter int PKT   = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(DEPTH)-1:0]  wr_ptr,
    input  logic [PKT*8-1:0]          wr_data,
    input  logic                      rd_en,
    input  logic                      rd_zero,
    input  logic [$clog2(DEPTH)-1:0]  rd_ptr,
    output logic [7:0]                rd_data
);

    localparam int PW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    // Store every byte of an accepted packet.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < PKT; k++) begin
                mem[wr_ptr + PW'(k)] <= wr_data[8*k +: 8];
            end
        end
    end

    // Return the oldest byte, or zero for a read that finds nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
        end else if (rd_en) begin
            rd_data <= mem[rd_ptr];
        end else if (rd_zero) begin
            rd_data <= 8'h00;
        end
    end

    // R6
    // empty_read_chk
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |=> (rd_data == 8'h00));

endmodule

// File: rtl/imu_fifo_irq.sv
// Flag generation and interrupt routing for the packet FIFO.
// Holds the watermark and the two enable bits; drives the active-low line.
// Assumes the count input comes from a register.
module imu_fifo_irq #(
    parameter int DEPTH = 2048,
    parameter int PKT   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic                        cfg_full_en,
    input  logic                        cfg_ths_en,
    input  logic [$clog2(DEPTH+1)-1:0]  cfg_wm,
    input  logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        full_flag,
    output logic                        ths_flag,
    output logic                        int_n
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_AT = CW'(DEPTH - PKT);

    logic          full_en_q;
    logic          ths_en_q;
    logic [CW-1:0] wm_q;

    // Configuration fields for the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_en_q <= 1'b0;
            ths_en_q  <= 1'b0;
            wm_q      <= '0;
        end else if (cfg_we) begin
            full_en_q <= cfg_full_en;
            ths_en_q  <= cfg_ths_en;
            wm_q      <= cfg_wm;
        end
    end

    // Level flags and the gated, inverted interrupt.
    always_comb begin
        full_flag = (count > FULL_AT);
        ths_flag  = (wm_q != '0) && (count >= wm_q);
        int_n     = !((full_flag && full_en_q) || (ths_flag && ths_en_q));
    end

    // R10
    // irq_quiet_chk
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_en_q && !ths_en_q) |-> int_n);

    // R9
    // full_room_chk
    full_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_flag |-> (CW'(DEPTH) - count >= CW'(PKT)));

endmodule

// File: rtl/imu_sample_fifo.sv
// Top of the sensor packet FIFO: joins policy control, byte storage and
// interrupt routing. Packets arrive whole; the host drains bytes one by one.
// Assumes a synchronous active-low reset held for at least one clock.
module imu_sample_fifo
    import imu_fifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int PKT   = 12,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_mode,
    input  logic            cfg_full_en,
    input  logic            cfg_ths_en,
    input  logic [CW-1:0]   cfg_wm,
    input  logic            pkt_valid,
    input  logic [PKT*8-1:0] pkt_data,
    input  logic            rd_req,
    output logic [7:0]      rd_data,
    output logic [CW-1:0]   byte_count,
    output logic            full_flag,
    output logic            ths_flag,
    output logic            int_n
);

    logic          wr_en;
    logic [PW-1:0] wr_ptr;
    logic          rd_en;
    logic          rd_zero;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    imu_fifo_ctrl #(.DEPTH(DEPTH), .PKT(PKT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_mode  (fill_mode_e'(cfg_mode)),
        .pkt_valid (pkt_valid),
        .rd_req    (rd_req),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .rd_en     (rd_en),
        .rd_zero   (rd_zero),
        .rd_ptr    (rd_ptr),
        .count     (count)
    );

    imu_fifo_store #(.DEPTH(DEPTH), .PKT(PKT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (pkt_data),
        .rd_en   (rd_en),
        .rd_zero (rd_zero),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data)
    );

    imu_fifo_irq #(.DEPTH(DEPTH), .PKT(PKT)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_full_en (cfg_full_en),
        .cfg_ths_en  (cfg_ths_en),
        .cfg_wm      (cfg_wm),
        .count       (count),
        .full_flag   (full_flag),
        .ths_flag    (ths_flag),
        .int_n       (int_n)
    );

    // Expose the registered count.
    always_comb begin
        byte_count = count;
    end

    // R3
    // pkt_step_chk
    pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && count <= CW'(DEPTH - PKT)) |=> (byte_count == $past(count) + CW'(PKT)));

endmodule

// File: tb/imu_sample_fifo_bench.sv
// Self-checking bench with a behavioural queue model compared every clock.
module imu_sample_fifo_bench;

    localparam int CLK_NS = 10;
    localparam int DEPTH  = 2048;
    localparam int PKT    = 12;
    localparam int CW     = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_mode = 2'b00;
    logic            cfg_full_en = 1'b0;
    logic            cfg_ths_en = 1'b0;
    logic [CW-1:0]   cfg_wm = '0;
    logic            pkt_valid = 1'b0;
    logic [PKT*8-1:0] pkt_data = '0;
    logic            rd_req = 1'b0;
    logic [7:0]      rd_data;
    logic [CW-1:0]   byte_count;
    logic            full_flag;
    logic            ths_flag;
    logic            int_n;

    imu_sample_fifo u_imu_sample_fifo (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_mode (cfg_mode),
        .cfg_full_en (cfg_full_en), .cfg_ths_en (cfg_ths_en), .cfg_wm (cfg_wm),
        .pkt_valid (pkt_valid), .pkt_data (pkt_data), .rd_req (rd_req),
        .rd_data (rd_data), .byte_count (byte_count), .full_flag (full_flag),
        .ths_flag (ths_flag), .int_n (int_n)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Reference state
    byte unsigned q[$];
    int   m_mode = 0;
    bit   m_fe = 0, m_te = 0;
    int   m_wm = 0;
    int   m_ofs = 0;
    int   m_rd = 0;
    int   total = 0, bad = 0;
    int   seq = 0;
    string cur_req = "R1";

    task automatic model_step();
        bit flush, rdok;
        int free_b, drop;
        if (!rst_n) begin
            q.delete(); m_mode = 0; m_fe = 0; m_te = 0; m_wm = 0; m_ofs = 0; m_rd = 0;
            return;
        end
        flush = cfg_we && (int'(cfg_mode) != m_mode);
        if (flush) begin
            q.delete(); m_ofs = 0;
            if (rd_req) m_rd = 0;
        end else begin
            rdok = rd_req && (q.size() > 0);
            if (rd_req) m_rd = rdok ? int'(q[0]) : 0;
            free_b = DEPTH - q.size();
            if (pkt_valid && m_mode == 3 && free_b < PKT) begin
                drop = PKT - m_ofs;
                if (free_b + drop < PKT) drop += PKT;
                repeat (drop) void'(q.pop_front());
                m_ofs = 0;
                for (int k = 0; k < PKT; k++) q.push_back(pkt_data[8*k +: 8]);
            end else begin
                if (rdok) begin
                    void'(q.pop_front());
                    m_ofs = (m_ofs + 1) % PKT;
                end
                if (pkt_valid && (m_mode == 3 || (m_mode == 1 && free_b >= PKT)))
                    for (int k = 0; k < PKT; k++) q.push_back(pkt_data[8*k +: 8]);
            end
        end
        if (cfg_we) begin
            m_mode = int'(cfg_mode); m_fe = cfg_full_en; m_te = cfg_ths_en; m_wm = int'(cfg_wm);
        end
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit ef, et;
        ef = q.size() > DEPTH - PKT;
        et = (m_wm != 0) && (q.size() >= m_wm);
        chk("byte_count", 32'(byte_count), 32'(q.size()));
        chk("rd_data", 32'(rd_data), 32'(m_rd));
        chk("full_flag", 32'(full_flag), 32'(ef));
        chk("ths_flag", 32'(ths_flag), 32'(et));
        chk("int_n", 32'(int_n), 32'(!((ef && m_fe) || (et && m_te))));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare();
        cfg_we = 1'b0; pkt_valid = 1'b0; rd_req = 1'b0;
    endtask

    function automatic logic [PKT*8-1:0] mk(int s);
        logic [PKT*8-1:0] d;
        for (int k = 0; k < PKT; k++) d[8*k +: 8] = 8'(s * 5 + k * 17 + 3);
        return d;
    endfunction

    task automatic put(bit with_rd);
        pkt_valid = 1'b1; pkt_data = mk(seq); seq++; rd_req = with_rd;
        cyc();
    endtask

    task automatic rd(int n);
        for (int i = 0; i < n; i++) begin rd_req = 1'b1; cyc(); end
    endtask

    task automatic cfg(logic [1:0] md, bit fe, bit te, int wm);
        cfg_we = 1'b1; cfg_mode = md; cfg_full_en = fe; cfg_ths_en = te; cfg_wm = CW'(wm);
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cur_req = "R1"; repeat (2) cyc();
        // R2: bypass and reserved code ignore packets
        cur_req = "R2"; repeat (4) put(0);
        cfg(2'b10, 0, 0, 0); repeat (4) put(0);
        // R3: byte order and count step in hold mode
        cur_req = "R3"; cfg(2'b01, 0, 0, 0); repeat (3) put(0); rd(36);
        // R6: empty reads, simultaneous read and accept
        cur_req = "R6"; rd(3); put(0); put(1); put(1); rd(30);
        // R8: watermark at 120 bytes, threshold enabled
        cur_req = "R8"; cfg(2'b01, 0, 1, 120); repeat (10) put(0); rd(1); rd(119);
        // R10: enables cleared keep the line high
        cur_req = "R10"; cfg(2'b01, 0, 0, 120); repeat (10) put(0); rd(120);
        // R4 and R9: hold mode fills, then rejects
        cur_req = "R4"; cfg(2'b01, 1, 0, 0); repeat (175) put(0);
        cur_req = "R9"; put(1); rd(5); put(0); put(0);
        // R7: same code keeps, new code flushes with packet and read ignored
        cur_req = "R7"; cfg(2'b01, 1, 0, 0);
        pkt_valid = 1'b1; pkt_data = mk(seq); seq++; rd_req = 1'b1; cfg(2'b11, 1, 1, 600);
        // R5: ring mode overwrite including the double discard
        cur_req = "R5"; repeat (172) put(0); rd(5); repeat (3) put(0);
        rd(11); put(0); put(0);
        rd(11); put(0);
        // R11: read during overwrite
        cur_req = "R11"; repeat (4) put(1); rd(7); put(1); put(1);
        cur_req = "R3"; rd(2100);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule